// File: doc/BRIEF.md
# Shared PCM/DSD Serial Audio Receiver

This block turns three serial audio lines (bit clock, word clock and data) into parallel left and right words. The lines are sampled by a faster system clock through a two-stage synchronizer, and the block acts on edges of the synchronized bit clock. In PCM mode it reads I2S or left-justified frames with a word length of 16, 24 or 32 bits. The frame may be longer than the word: 32, 48 or 64 bit clocks per sample period are all accepted. Each received sample is placed MSB-aligned in a 32-bit output word.

In DSD mode the same pins carry two raw one-bit streams, and the bit clock acts as the DSD clock. The data pin carries the left stream and the word-clock pin carries the right stream. Each stream is packed MSB-first into 32-bit words. The mode is chosen only by a configuration input, and the block never detects the mode from the incoming signal. A channel swap and a mono selection are applied when the output words are registered. The swap lets a source that uses the other channel convention be remapped.

Top module: `pcmdsd_rx`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_l` and `out_r` are all zeros.
- R2: `fmt` selects the PCM format: 0 is left-justified 16-bit, 1 is left-justified 24-bit, 2 is left-justified 32-bit, 3 is I2S 16-bit, 4 is I2S 24-bit, and 5 to 7 are I2S 32-bit. A received sample appears in bits [31:32-N] of the output word, and the lower bits are zero.
- R3: In I2S framing, the left channel is sent while the word clock is low, and the MSB arrives on the second bit clock after the word-clock change. In left-justified framing, the left channel is sent while the word clock is high, and the MSB arrives on the same bit clock as the change.
- R4: PCM data is sampled on the rising bit-clock edge. Bits after the word length within a half-frame are ignored, so 32-, 48- and 64-bit-clock frames all give the same samples.
- R5: `out_valid` pulses for one system-clock cycle. In PCM mode it pulses when a right word completes after a left word has completed.
- R6: In DSD mode, the data pin is the left stream and the word-clock pin is the right stream. Each stream is packed MSB-first into a 32-bit word. `out_valid` pulses once every 32 DSD clock edges, and the operation does not depend on the DSD clock rate.
- R7: In DSD mode, `dsd_fall`=0 samples on the rising DSD clock edge and `dsd_fall`=1 samples on the falling edge.
- R8: With `mono`=0 and `swap`=1, the left input is delivered on `out_r` and the right input on `out_l`.
- R9: With `mono`=1, both outputs carry the left input (`mono_sel`=0) or the right input (`mono_sel`=1), and `swap` has no effect.
- R10: Any change of `dsd_mode`, `fmt` or `dsd_fall` discards partly received words. No strobe follows until a complete word (DSD) or a complete left-then-right pair (PCM) has been received in the new setting.
- R11: `out_l` and `out_r` change only in the cycle in which `out_valid` is high, and they hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsd_mode | input | 1 | 0 selects PCM, 1 selects DSD |
| fmt | input | 3 | PCM framing and word length |
| dsd_fall | input | 1 | DSD sampling edge: 0 rising, 1 falling |
| swap | input | 1 | Exchange channels at the output (stereo only) |
| mono | input | 1 | Send one channel to both outputs |
| mono_sel | input | 1 | Mono source: 0 left, 1 right |
| sclk_in | input | 1 | Bit clock / DSD clock pin |
| wclk_in | input | 1 | Word clock / right DSD data pin |
| sdat_in | input | 1 | PCM data / left DSD data pin |
| out_l | output | 32 | Left output word |
| out_r | output | 32 | Right output word |
| out_valid | output | 1 | One-cycle strobe marking a new output pair |

## Verification
Two events can land on the same bit clock: completion of one channel's word and the word-clock change that opens the next channel. In I2S framing with a half-frame exactly as long as the word, the left LSB is sampled on the very edge where the word clock already shows the right channel. The bench provokes this case with 16-bit I2S in 32-clock frames and 32-bit I2S in 64-clock frames. The scoreboard then requires both words to arrive exactly. A second pairing, a configuration change against a half-received word, is judged by the absence of any strobe before the next full word.

// File: rtl/pcmdsd_rx.sv
module pcmdsd_rx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dsd_mode,
  input  logic [2:0]   fmt,
  input  logic         dsd_fall,
  input  logic         swap,
  input  logic         mono,
  input  logic         mono_sel,
  input  logic         sclk_in,
  input  logic         wclk_in,
  input  logic         sdat_in,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r,
  output logic         out_valid
);

  localparam int CW  = $clog2(W) + 1;
  localparam int DCW = $clog2(W);
  localparam logic [CW-1:0]  CMAX = '1;
  localparam logic [CW-1:0]  WV   = CW'(W);
  localparam logic [DCW-1:0] DLST = DCW'(W - 1);

  // line synchronizers; all three lines share the same depth
  logic [2:0] sck;
  logic [1:0] wck, sdt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck <= '0;
      wck <= '0;
      sdt <= '0;
    end else begin
      sck <= {sck[1:0], sclk_in};
      wck <= {wck[0], wclk_in};
      sdt <= {sdt[0], sdat_in};
    end

  logic rise, fall, wbit, dbit;
  assign rise = sck[1] & ~sck[2];
  assign fall = ~sck[1] & sck[2];
  assign wbit = wck[1];
  assign dbit = sdt[1];

  // R10: any configuration change flushes partial words
  logic [4:0] cfg_q;
  logic       flush;
  assign flush = ({dsd_fall, dsd_mode, fmt} != cfg_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {dsd_fall, dsd_mode, fmt};

  // R2: format decode
  logic          i2s;
  logic [CW-1:0] wlen;
  assign i2s = (fmt >= 3'd3);

  always_comb
    case (fmt)
      3'd0, 3'd3: wlen = CW'(16);
      3'd1, 3'd4: wlen = CW'(24);
      default:    wlen = CW'(32);
    endcase

  // PCM deserializer (R3, R4)
  logic          wp1, wp2, started, left_ok;
  logic [1:0]    seen;
  logic [CW-1:0] cnt, idx;
  logic [W-1:0]  sh, sh_nx, lhold, aligned;
  logic          pedge, hist_ok, eff_w, eff_p, trans, take, cap, done, ch_r;

  assign pedge   = rise & ~dsd_mode;
  assign hist_ok = i2s ? (seen == 2'd2) : (seen != 2'd0);
  assign eff_w   = i2s ? wp1 : wbit;
  assign eff_p   = i2s ? wp2 : wp1;
  assign trans   = hist_ok & (eff_w ^ eff_p);
  assign idx     = trans ? '0 : cnt;
  assign take    = pedge & (trans | started);
  assign cap     = take & (idx < wlen);
  assign done    = cap & (idx == wlen - 1'b1);
  assign ch_r    = i2s ? eff_w : ~eff_w;
  assign sh_nx   = {sh[W-2:0], dbit};
  assign aligned = sh_nx << (WV - wlen);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp1     <= 1'b0;
      wp2     <= 1'b0;
      seen    <= '0;
      started <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      lhold   <= '0;
      left_ok <= 1'b0;
    end else if (flush) begin
      seen    <= '0;
      started <= 1'b0;
      cnt     <= '0;
      left_ok <= 1'b0;
    end else if (pedge) begin
      wp1 <= wbit;
      wp2 <= wp1;
      if (seen != 2'd2) seen <= seen + 2'd1;
      if (take) begin
        started <= 1'b1;
        cnt     <= (idx == CMAX) ? CMAX : idx + 1'b1;
      end
      if (cap) sh <= sh_nx;
      if (done && !ch_r) begin
        lhold   <= aligned;
        left_ok <= 1'b1;
      end
      if (done && ch_r) left_ok <= 1'b0;
    end

  // DSD packer (R6, R7)
  logic [W-1:0]   dl, dr, dl_nx, dr_nx;
  logic [DCW-1:0] dcnt;
  logic           dedge, ddone;

  assign dedge = dsd_mode & (dsd_fall ? fall : rise);
  assign ddone = dedge & (dcnt == DLST);
  assign dl_nx = {dl[W-2:0], dbit};
  assign dr_nx = {dr[W-2:0], wbit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dl   <= '0;
      dr   <= '0;
      dcnt <= '0;
    end else if (flush) begin
      dcnt <= '0;
    end else if (dedge) begin
      dl   <= dl_nx;
      dr   <= dr_nx;
      dcnt <= ddone ? '0 : dcnt + 1'b1;
    end

  // output stage (R5, R8, R9, R11)
  logic         emit;
  logic [W-1:0] src_l, src_r, msrc;
  assign emit  = ~flush & (ddone | (done & ch_r & left_ok));
  assign src_l = dsd_mode ? dl_nx : lhold;
  assign src_r = dsd_mode ? dr_nx : aligned;
  assign msrc  = mono_sel ? src_r : src_l;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        if (mono) begin
          out_l <= msrc;
          out_r <= msrc;
        end else if (swap) begin
          out_l <= src_r;
          out_r <= src_l;
        end else begin
          out_l <= src_l;
          out_r <= src_r;
        end
      end
    end

endmodule

// File: rtl/pcmdsd_rx_chk.sv
module pcmdsd_rx_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dsd_mode,
  input logic [2:0]   fmt,
  input logic         dsd_fall,
  input logic         mono,
  input logic [W-1:0] out_l,
  input logic [W-1:0] out_r,
  input logic         out_valid
);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_mono_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mono)) |-> (out_l == out_r));

  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({dsd_fall, dsd_mode, fmt}) |=> !out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_l) && $stable(out_r)));

  assert_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(out_valid));

endmodule

bind pcmdsd_rx pcmdsd_rx_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dsd_mode(dsd_mode), .fmt(fmt), .dsd_fall(dsd_fall),
  .mono(mono), .out_l(out_l), .out_r(out_r), .out_valid(out_valid)
);

// File: tb/pcmdsd_rx_test.sv
module pcmdsd_rx_test;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, dsd_mode, dsd_fall, swap, mono, mono_sel;
  logic sclk_in, wclk_in, sdat_in;
  logic [2:0]  fmt;
  logic [31:0] out_l, out_r;
  logic        out_valid;

  pcmdsd_rx uut (
    .clk(clk), .rst_n(rst_n), .dsd_mode(dsd_mode), .fmt(fmt), .dsd_fall(dsd_fall),
    .swap(swap), .mono(mono), .mono_sel(mono_sel), .sclk_in(sclk_in),
    .wclk_in(wclk_in), .sdat_in(sdat_in), .out_l(out_l), .out_r(out_r),
    .out_valid(out_valid)
  );

  logic [63:0] expq[$];
  string       tagq[$];
  int          total = 0, bad = 0;
  string       cur_tag = "R1";
  logic        carry = 1'b1;
  logic [31:0] last_l = '0, last_r = '0;
  logic [63:0] mon_e;
  string       mon_t;
  bit          fin = 1'b0;

  function automatic int wl_of(input logic [2:0] f);
    case (f)
      3'd0, 3'd3: return 16;
      3'd1, 3'd4: return 24;
      default:    return 32;
    endcase
  endfunction

  function automatic logic [31:0] trunc_w(input logic [31:0] v, input int wl);
    return v & (32'hFFFF_FFFF << (32 - wl));
  endfunction

  function automatic logic bit_of(input logic [31:0] v, input int k, input int wl);
    if (k < wl) return v[31-k];
    return (k % 2 == 0);
  endfunction

  task automatic push(input logic [31:0] l, input logic [31:0] r, input string tag);
    logic [31:0] s;
    s = mono_sel ? r : l;
    if (mono)      expq.push_back({s, s});
    else if (swap) expq.push_back({r, l});
    else           expq.push_back({l, r});
    tagq.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !fin) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected strobe actual=%h_%h expected=none", cur_tag, out_l, out_r);
      end else begin
        mon_e = expq.pop_front();
        mon_t = tagq.pop_front();
        last_l = mon_e[63:32];
        last_r = mon_e[31:0];
        if ({out_l, out_r} !== mon_e) begin
          bad++;
          $display("FAIL %s: actual=%h_%h expected=%h_%h", mon_t, out_l, out_r,
                   mon_e[63:32], mon_e[31:0]);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic w, input logic d, input int h);
    if (dsd_mode && dsd_fall) begin
      sclk_in = 1'b1; wclk_in = ~w; sdat_in = ~d;
      idle(h);
      wclk_in = w; sdat_in = d;
      idle(h);
      sclk_in = 1'b0;
      idle(h);
    end else begin
      sclk_in = 1'b0; wclk_in = w; sdat_in = d;
      idle(h);
      sclk_in = 1'b1;
      idle(h);
    end
  endtask

  task automatic setcfg(input logic dm, input logic [2:0] f, input logic fl,
                        input logic sw, input logic mo, input logic ms);
    idle(8);
    dsd_mode = dm; fmt = f; dsd_fall = fl; swap = sw; mono = mo; mono_sel = ms;
    idle(8);
  endtask

  function automatic logic left_lvl();
    return (fmt >= 3'd3) ? 1'b0 : 1'b1;
  endfunction

  task automatic pcm_lead(input int h);
    repeat (2) send_bit(~left_lvl(), 1'b1, h);
    carry = 1'b1;
  endtask

  task automatic pcm_tail(input int h);
    send_bit(left_lvl(), carry, h);
    idle(12);
  endtask

  // sends up to nmax bit clocks of one frame; pushes an expectation only if complete
  task automatic pcm_frame(input logic [31:0] l, input logic [31:0] r, input int half,
                           input int h, input string tag, input int nmax);
    int wl, sent;
    logic i2s, lv, d;
    logic [31:0] v;
    wl = wl_of(fmt);
    i2s = (fmt >= 3'd3);
    lv = left_lvl();
    sent = 0;
    cur_tag = tag;
    if (nmax >= 2 * half) push(trunc_w(l, wl), trunc_w(r, wl), tag);
    for (int ch = 0; ch < 2; ch++) begin
      v = (ch == 0) ? l : r;
      for (int p = 0; p < half; p++) begin
        if (i2s) begin
          d = (p == 0) ? carry : bit_of(v, p - 1, wl);
          if (p == half - 1) carry = bit_of(v, half - 1, wl);
        end else begin
          d = bit_of(v, p, wl);
        end
        if (sent < nmax) send_bit((ch == 0) ? lv : ~lv, d, h);
        sent++;
      end
    end
  endtask

  task automatic dsd_words(input logic [31:0] l, input logic [31:0] r, input int h,
                           input int nbits, input string tag);
    cur_tag = tag;
    if (nbits == 32) push(l, r, tag);
    for (int k = 0; k < nbits; k++) send_bit(r[31-k], l[31-k], h);
    idle(10);
  endtask

  task automatic check_quiet(input string tag);
    idle(20);
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL %s: missing strobes actual=%0d pending expected=0", tag, expq.size());
      expq.delete();
      tagq.delete();
    end
    total++;
    if (out_l !== last_l || out_r !== last_r) begin
      bad++;
      $display("FAIL R11: held output actual=%h_%h expected=%h_%h", out_l, out_r, last_l, last_r);
    end
  endtask

  task automatic finish_run();
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL R5: watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; dsd_mode = 1'b0; fmt = 3'd0; dsd_fall = 1'b0;
    swap = 1'b0; mono = 1'b0; mono_sel = 1'b0;
    sclk_in = 1'b0; wclk_in = 1'b0; sdat_in = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    total++;
    if (out_valid !== 1'b0 || out_l !== '0 || out_r !== '0) begin
      bad++;
      $display("FAIL R1: reset actual=%b %h %h expected=0 0 0", out_valid, out_l, out_r);
    end

    // R2 R3 R4: left-justified, 16/24/32 bits, 32- and 64-clock frames
    pcm_lead(2);
    pcm_frame(32'hA5C3_0000, 32'h5A3C_0000, 16, 2, "R2", 999);
    pcm_frame(32'h8001_0000, 32'h7FFE_0000, 16, 2, "R3", 999);
    pcm_tail(2);
    check_quiet("R2");
    setcfg(1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    pcm_lead(2);
    pcm_frame(32'h1234_56FF, 32'hFEDC_BA00, 32, 2, "R4", 999);
    pcm_tail(2);
    check_quiet("R4");
    setcfg(1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    pcm_lead(2);
    pcm_frame(32'hDEAD_BEEF, 32'h0123_4567, 32, 2, "R2", 999);
    pcm_tail(2);
    check_quiet("R2");

    // R3: I2S, word end and word-clock edge on one bit clock
    setcfg(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    pcm_lead(2);
    pcm_frame(32'hC001_0000, 32'h0003_0000, 16, 2, "R3", 999);
    pcm_frame(32'h7FFF_0000, 32'h8001_0000, 16, 2, "R3", 999);
    pcm_tail(2);
    check_quiet("R3");
    setcfg(1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
    pcm_lead(2);
    pcm_frame(32'h9ABC_DE55, 32'h1357_9BAA, 24, 2, "R4", 999);
    pcm_tail(2);
    check_quiet("R4");
    setcfg(1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    pcm_lead(2);
    pcm_frame(32'h8000_0001, 32'hFFFF_FFFE, 32, 2, "R3", 999);
    pcm_tail(2);
    check_quiet("R3");
    setcfg(1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    pcm_lead(3);
    pcm_frame(32'h4321_FFFF, 32'hBEEF_FFFF, 32, 3, "R4", 999);
    pcm_tail(3);
    check_quiet("R4");

    // R8 swap, R9 mono with swap ignored
    setcfg(1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0);
    pcm_lead(2);
    pcm_frame(32'h1111_1100, 32'h2222_2200, 24, 2, "R8", 999);
    pcm_tail(2);
    check_quiet("R8");
    setcfg(1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 1'b0);
    pcm_lead(2);
    pcm_frame(32'h3333_3300, 32'h4444_4400, 24, 2, "R9", 999);
    pcm_tail(2);
    check_quiet("R9");
    setcfg(1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1);
    pcm_lead(2);
    pcm_frame(32'h5555_5500, 32'h6666_6600, 24, 2, "R9", 999);
    pcm_tail(2);
    check_quiet("R9");

    // R6 DSD pin mapping at two clock rates, R8 with DSD, R7 falling edge
    setcfg(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
    dsd_words(32'hF0E1_D2C3, 32'h0F1E_2D3C, 4, 32, "R6");
    dsd_words(32'h1234_5678, 32'h9ABC_DEF0, 2, 32, "R6");
    check_quiet("R6");
    setcfg(1'b1, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0);
    dsd_words(32'hAAAA_0000, 32'h0000_5555, 2, 32, "R8");
    check_quiet("R8");
    setcfg(1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0);
    dsd_words(32'hC3A5_96E1, 32'h3C5A_691E, 2, 32, "R7");
    dsd_words(32'h0000_FFFF, 32'hFFFF_0000, 3, 32, "R7");
    check_quiet("R7");

    // R10: partial DSD word, then switch to PCM
    setcfg(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    dsd_words(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2, 20, "R10");
    setcfg(1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    check_quiet("R10");
    pcm_lead(2);
    pcm_frame(32'h7654_3200, 32'h0ABC_DE00, 32, 2, "R10", 999);
    pcm_tail(2);
    check_quiet("R10");

    // R10: left complete, right partial, then format change
    pcm_lead(2);
    pcm_frame(32'h1111_1100, 32'hEEEE_EE00, 32, 2, "R10", 32 + 20);
    setcfg(1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
    check_quiet("R10");
    pcm_lead(2);
    pcm_frame(32'h2468_AC00, 32'h1357_9B00, 32, 2, "R10", 999);
    pcm_tail(2);
    check_quiet("R10");

    // R10: partial DSD word, then sampling edge change
    setcfg(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
    dsd_words(32'h0F0F_0F0F, 32'hF0F0_F0F0, 2, 12, "R10");
    setcfg(1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0);
    dsd_words(32'h5A5A_A5A5, 32'hA5A5_5A5A, 2, 32, "R10");
    check_quiet("R10");

    finish_run();
  end
endmodule